// File: doc/BRIEF.md
# Single-Shot and Continuous Conversion Sequencer

This block decides when a converter core runs. It holds a small configuration register with a start/busy flag, a mode select, a two-bit rate code and a two-bit gain code. From these it drives the converter's power enable and a one-cycle start pulse. It also captures each finished result in an output register, together with a new-data flag. A serial-bus front end, outside this block, turns host transactions into register write and read strobes. The same front end decodes the bus-wide reset command into a single pulse.

In continuous mode the converter stays powered and starts a new conversion as soon as the previous one finishes. In single mode the converter stays powered down until the host writes a 1 to start/busy. It then runs exactly one conversion, stores the result and powers down again. The rate and gain codes are captured at each start and passed to the converter, so a change made part-way through a conversion first applies to the next one.

Top module: `conv_seq_ctrl`

## Requirements
- R1: After power-on reset the configuration reads 0x8C: continuous mode (bit 4 = 0), rate code 3 (bits 3:2), gain code 0 (bits 1:0), and start/busy (bit 7) reading 1. At the same time conv_en is 0, new_data is 0 and the result register is 0.
- R2: In continuous mode a conversion starts one cycle after reset is released, with conv_start high for one cycle and conv_en high. Each accepted conv_done stores the result and restarts the converter on the next cycle, with no idle cycle between conversions.
- R3: While continuous mode is selected, the start/busy bit (bit 7) of the configuration read value is always 1.
- R4: In single mode with no conversion running, conv_en stays 0 and no start is issued. A write with bit 4 = 1 and bit 7 = 1 starts one conversion on the next cycle. When that conversion finishes, the result is stored, start/busy reads 0 and conv_en drops.
- R5: Writing 1 to start/busy while a conversion is running has no effect. No extra start pulse is issued, and no second conversion follows the current one.
- R6: Switching from continuous to single mode during a conversion keeps conv_en high until that conversion finishes. After it finishes, start/busy reads 0 and the converter powers down.
- R7: A gen_reset pulse returns every register to its power-on value in the next cycle: configuration 0x8C, new_data 0, result 0, conv_en 0. From there the block continues exactly as it does after power-on.
- R8: conv_rate and conv_gain are loaded only when a conversion starts. A rate or gain write made during a conversion leaves them unchanged until the next start. Gain codes 0 to 3 select gains 1, 2, 4 and 8.
- R9: new_data goes to 1 in the cycle after a result is stored and goes to 0 in the cycle after res_rd. When a result is stored in the same cycle as a read, new_data stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| gen_reset | input | 1 | Bus-wide reset pulse, synchronous |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read value |
| res_rd | input | 1 | Output register read strobe |
| res_rdata | output | RES_W | Latched conversion result |
| new_data | output | 1 | Unread result present |
| conv_done | input | 1 | Converter finished pulse |
| conv_result | input | RES_W | Converter result, valid with conv_done |
| conv_en | output | 1 | Converter power enable |
| conv_start | output | 1 | One-cycle conversion start |
| conv_rate | output | 2 | Rate code captured at start |
| conv_gain | output | 2 | Gain code captured at start |

## Verification
Some properties are checked on every cycle:
- Continuous mode never reports idle.
- A start pulse never occurs with the converter powered down.
- A busy converter with no done pulse is never restarted.
- A finished single-mode conversion powers down.
- The rate code never moves except at a start.
- new_data rises only after a done pulse.

Other behaviour needs the bench's scenarios to show it:
- A rate change written mid-conversion appears only on the next start.
- Back-to-back continuous restarts happen with no gap.
- A start/busy write during a conversion produces no second conversion.
- The bus-wide reset restores exactly the power-on state.

// File: rtl/conv_seq_ctrl.sv
module conv_seq_ctrl #(
  parameter int          RES_W    = 16,
  parameter logic [1:0]  RATE_DEF = 2'b11,
  parameter logic [1:0]  GAIN_DEF = 2'b00
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gen_reset,
  input  logic             cfg_we,
  input  logic [7:0]       cfg_wdata,
  output logic [7:0]       cfg_rdata,
  input  logic             res_rd,
  output logic [RES_W-1:0] res_rdata,
  output logic             new_data,
  input  logic             conv_done,
  input  logic [RES_W-1:0] conv_result,
  output logic             conv_en,
  output logic             conv_start,
  output logic [1:0]       conv_rate,
  output logic [1:0]       conv_gain
);
  localparam int SB_BIT   = 7;
  localparam int MODE_BIT = 4;

  logic       mode_single;
  logic [1:0] rate_cfg, gain_cfg;
  logic       busy;

  wire       mode_nx = cfg_we ? cfg_wdata[MODE_BIT] : mode_single;
  wire [1:0] rate_nx = cfg_we ? cfg_wdata[3:2] : rate_cfg;
  wire [1:0] gain_nx = cfg_we ? cfg_wdata[1:0] : gain_cfg;
  wire       kick    = cfg_we & cfg_wdata[SB_BIT] & cfg_wdata[MODE_BIT];
  wire       done_ok = conv_done & busy;
  wire       launch  = (~busy & (~mode_nx | kick)) | (done_ok & ~mode_nx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_single <= 1'b0;
      rate_cfg    <= RATE_DEF;
      gain_cfg    <= GAIN_DEF;
      busy        <= 1'b0;
      conv_start  <= 1'b0;
      conv_rate   <= RATE_DEF;
      conv_gain   <= GAIN_DEF;
      res_rdata   <= '0;
      new_data    <= 1'b0;
    end else if (gen_reset) begin
      mode_single <= 1'b0;
      rate_cfg    <= RATE_DEF;
      gain_cfg    <= GAIN_DEF;
      busy        <= 1'b0;
      conv_start  <= 1'b0;
      conv_rate   <= RATE_DEF;
      conv_gain   <= GAIN_DEF;
      res_rdata   <= '0;
      new_data    <= 1'b0;
    end else begin
      mode_single <= mode_nx;
      rate_cfg    <= rate_nx;
      gain_cfg    <= gain_nx;
      busy        <= launch | (busy & ~conv_done);
      conv_start  <= launch;
      if (launch) begin
        conv_rate <= rate_nx;
        conv_gain <= gain_nx;
      end
      if (done_ok) res_rdata <= conv_result;
      new_data    <= done_ok | (new_data & ~res_rd);
    end
  end

  assign conv_en   = busy;
  assign cfg_rdata = {~mode_single | busy, 2'b00, mode_single, rate_cfg, gain_cfg};
endmodule

// File: rtl/conv_seq_ctrl_chk.sv
module conv_seq_ctrl_chk #(
  parameter int RES_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             gen_reset,
  input logic             cfg_we,
  input logic [7:0]       cfg_rdata,
  input logic             new_data,
  input logic             conv_done,
  input logic             conv_en,
  input logic             conv_start,
  input logic [1:0]       conv_rate,
  input logic [RES_W-1:0] res_rdata
);
  p_cont_reads_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rdata[4] |-> cfg_rdata[7]);

  p_start_powered_r2: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> conv_en);

  p_no_restart_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_en && !conv_done && !gen_reset) |=> !conv_start);

  p_single_powers_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_en && conv_done && cfg_rdata[4] && !cfg_we && !gen_reset) |=> !conv_en);

  p_rate_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!conv_start && !$past(gen_reset)) |-> $stable(conv_rate));

  p_flag_after_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(new_data) |-> $past(conv_done));
endmodule

bind conv_seq_ctrl conv_seq_ctrl_chk #(.RES_W(RES_W)) chk_i (.*);

// File: tb/conv_seq_ctrl_tb_top.sv
module conv_seq_ctrl_tb_top;
  localparam int RW = 16;
  logic clk = 1'b0;
  logic rst_n = 1'b0, gen_reset = 1'b0, cfg_we = 1'b0, res_rd = 1'b0, conv_done = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic [RW-1:0] conv_result = '0;
  logic [7:0] cfg_rdata;
  logic [RW-1:0] res_rdata;
  logic new_data, conv_en, conv_start;
  logic [1:0] conv_rate, conv_gain;

  int checks = 0, errors = 0;
  bit finished = 1'b0;
  logic [RW-1:0] exp_q[$];

  always #4 clk = ~clk;

  conv_seq_ctrl #(.RES_W(RW)) dut_i (
    .clk(clk), .rst_n(rst_n), .gen_reset(gen_reset), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .res_rd(res_rd),
    .res_rdata(res_rdata), .new_data(new_data), .conv_done(conv_done),
    .conv_result(conv_result), .conv_en(conv_en), .conv_start(conv_start),
    .conv_rate(conv_rate), .conv_gain(conv_gain));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(logic [7:0] d);
    cfg_we = 1'b1; cfg_wdata = d; step(); cfg_we = 1'b0;
  endtask

  task automatic finish_conv(logic [RW-1:0] v);
    exp_q.push_back(v);
    conv_done = 1'b1; conv_result = v; step(); conv_done = 1'b0;
  endtask

  task automatic rd();
    res_rd = 1'b1; step(); res_rd = 1'b0;
  endtask

  logic nd_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_n && new_data && !nd_prev) begin
      if (exp_q.size() == 0) chk("R9 unexpected result", int'(res_rdata), -1);
      else chk("R2 result latched", int'(res_rdata), int'(exp_q.pop_front()));
    end
    nd_prev = new_data;
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual %0d expected <20000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    chk("R1 cfg", cfg_rdata, 8'h8C);
    chk("R1 conv_en", conv_en, 0);
    chk("R1 new_data", new_data, 0);
    chk("R1 result", res_rdata, 0);
    rst_n = 1'b1; step();
    chk("R2 start pulse", conv_start, 1);
    chk("R2 powered", conv_en, 1);
    chk("R8 default rate", conv_rate, 3);
    chk("R8 default gain", conv_gain, 0);
    step();
    chk("R2 start one cycle", conv_start, 0);
    chk("R3 sb reads 1", cfg_rdata[7], 1);
    // R8: change rate/gain mid-conversion
    wr(8'h06);
    chk("R8 cfg read", cfg_rdata, 8'h86);
    chk("R8 rate held", conv_rate, 3);
    chk("R8 gain held", conv_gain, 0);
    finish_conv(16'h1234);
    chk("R2 restart", conv_start, 1);
    chk("R2 still powered", conv_en, 1);
    chk("R8 new rate", conv_rate, 1);
    chk("R8 gain 4", conv_gain, 2);
    chk("R9 flag set", new_data, 1);
    rd();
    chk("R9 flag cleared", new_data, 0);
    // R6: switch to single mid-conversion
    wr(8'h16);
    chk("R6 still powered", conv_en, 1);
    chk("R6 sb busy", cfg_rdata, 8'h96);
    finish_conv(16'hBEEF);
    chk("R6 powered down", conv_en, 0);
    chk("R6 no restart", conv_start, 0);
    chk("R6 sb cleared", cfg_rdata, 8'h16);
    rd();
    repeat (4) step();
    chk("R4 idle", conv_en, 0);
    // R4: single shot
    wr(8'h9F);
    chk("R4 start", conv_start, 1);
    chk("R4 powered", conv_en, 1);
    chk("R8 gain 8", conv_gain, 3);
    chk("R8 rate 3", conv_rate, 3);
    // R5: start write while busy
    wr(8'h9F);
    chk("R5 no extra start", conv_start, 0);
    finish_conv(16'h8001);
    chk("R4 powered down", conv_en, 0);
    chk("R4 sb reads 0", cfg_rdata, 8'h1F);
    repeat (3) step();
    chk("R5 no second conversion", conv_en, 0);
    // R9: latch and read in same cycle keeps flag
    wr(8'h9F);
    rd();
    res_rd = 1'b1; finish_conv(16'h0042); res_rd = 1'b0;
    chk("R9 set wins", new_data, 1);
    // R7: bus reset with unread data
    gen_reset = 1'b1; step(); gen_reset = 1'b0;
    chk("R7 cfg", cfg_rdata, 8'h8C);
    chk("R7 new_data", new_data, 0);
    chk("R7 result", res_rdata, 0);
    chk("R7 conv_en", conv_en, 0);
    step();
    chk("R7 restart", conv_start, 1);
    chk("R7 rate", conv_rate, 3);
    finished = 1'b1;
    chk("R2 queue empty", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule